// File: doc/BRIEF.md
# Buck Stage Fault Arbiter

This block sits between the pulse-width modulator of a single-phase synchronous buck regulator and its two gate drivers. Each cycle it decides whether the high-side and low-side drive commands follow the modulator's requests or are overridden by a protection state. The protection states are supply lockout, a reverse-output guard, an overvoltage crowbar latch and a delayed overcurrent latch.

The analog comparators feed it single-bit flags. These are enable, supply-good, supply-under-lockout, overcurrent, power-good-failed, overvoltage, and three reverse-voltage levels: output below −190 mV, output above −150 mV, and output above +50 mV. Every flag is asynchronous to the block clock and is resynchronised before use. The two modulator requests are synchronous and act on the outputs in the same cycle. There is no data stream, so every pin is a plain level.

The latch-off delay is set in clock cycles by a parameter. Its default matches about 7 ms at 125 MHz.

Top module: `buck_fault_guard`

## Requirements
- R1: Every comparator and control flag passes through two synchronising flops before a state register. A flag applied before clock edge 1 changes the run or latch state at edge 3 and not earlier.
- R2: Running starts only when enable and supply-good are both high. Running continues while supply-good is low if lockout is also low, which gives the threshold hysteresis.
- R3: Enable low or lockout high stops running. Both drive outputs are then low, `pg_force_low_o` is 1 and `run_o` is 0.
- R4: In normal running, `drvh_o` follows `hs_req_i`. `drvl_o` follows `ls_req_i` only while `hs_req_i` is 0, so both requests high give drvh=1 and drvl=0.
- R5: When overcurrent and power-good-failed are both seen for `LATCH_DELAY` consecutive synchronised cycles, the block latches off with both outputs low and `latched_o`=1. A gap in either flag restarts the count.
- R6: An overvoltage flag while running sets a latched crowbar: drvh=0, drvl=1 and `latched_o`=1. The state stays after the flag clears, and requests have no effect.
- R7: Latched states clear only through shutdown, either a low pulse on enable or a lockout cycle. After the restart, `latched_o` is 0 and pass-through resumes.
- R8: Outside the crowbar, the below −190 mV flag forces both outputs low. They stay low until the above −150 mV flag is seen.
- R9: Inside the crowbar, the below −190 mV flag turns drvl off. drvl returns to 1 only when the above +50 mV flag is seen; the −150 mV flag alone does not release it.
- R10: Priority from highest to lowest is shutdown, reverse guard, crowbar, overcurrent latch, then pass-through. Shutdown during a crowbar gives both outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable request (asynchronous) |
| vcc_ok_i | input | 1 | Supply above start threshold |
| vcc_uvlo_i | input | 1 | Supply below lockout threshold |
| oc_i | input | 1 | Overcurrent flag |
| pg_fail_i | input | 1 | Power-good has dropped |
| ov_i | input | 1 | Output overvoltage flag |
| rv_low_i | input | 1 | Output below −190 mV |
| rv_rel_i | input | 1 | Output above −150 mV |
| rv_rec_i | input | 1 | Output above +50 mV |
| hs_req_i | input | 1 | Modulator high-side request |
| ls_req_i | input | 1 | Modulator low-side request |
| drvh_o | output | 1 | Final high-side drive command |
| drvl_o | output | 1 | Final low-side drive command |
| latched_o | output | 1 | An overcurrent or overvoltage latch is set |
| run_o | output | 1 | Block is running |
| pg_force_low_o | output | 1 | Power-good must be pulled low |

## Verification
The assertions assume the three reverse-voltage flags come from one monotonic output level. So the below −190 mV flag never sits high together with either release flag, and the +50 mV flag implies the −150 mV flag. They also assume supply-good and lockout are never high together. The bench drives each voltage step as one consistent flag set, changes flags only on falling clock edges, and holds each level for several cycles so that the synchroniser latency is always covered before a check.

// File: rtl/fg_pkg.sv
package fg_pkg;

  typedef struct packed {
    logic en;
    logic vcc_ok;
    logic uvlo;
    logic oc;
    logic pg_fail;
    logic ov;
    logic rv_low;
    logic rv_rel;
    logic rv_rec;
  } fg_flags_t;

  localparam int unsigned FLAG_W = $bits(fg_flags_t);

  typedef enum logic [2:0] {
    SEL_OFF     = 3'd0,
    SEL_REVERSE = 3'd1,
    SEL_CROWBAR = 3'd2,
    SEL_OCLATCH = 3'd3,
    SEL_PASS    = 3'd4
  } drive_sel_e;

endpackage

// File: rtl/fg_sync.sv
module fg_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/fg_supervisor.sv
module fg_supervisor (
  input  logic clk,
  input  logic rst_n,
  input  logic en_s,
  input  logic vcc_ok_s,
  input  logic uvlo_s,
  output logic run_q
);

  logic run_d;

  always_comb begin
    run_d = run_q;
    if (!en_s || uvlo_s)    run_d = 1'b0;
    else if (vcc_ok_s)      run_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

endmodule

// File: rtl/fg_fault_latch.sv
module fg_fault_latch #(
  parameter int unsigned LATCH_DELAY = 875000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic oc_s,
  input  logic pg_fail_s,
  input  logic ov_s,
  output logic oc_latch_q,
  output logic ov_latch_q
);

  localparam int unsigned CNT_W = (LATCH_DELAY > 1) ? $clog2(LATCH_DELAY + 1) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LATCH_DELAY - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             overload;

  assign overload = run && oc_s && pg_fail_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      oc_latch_q <= 1'b0;
    end else if (!run) begin
      cnt_q      <= '0;
      oc_latch_q <= 1'b0;
    end else if (!overload || oc_latch_q) begin
      cnt_q      <= '0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_q      <= '0;
      oc_latch_q <= 1'b1;
    end else begin
      cnt_q      <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ov_latch_q <= 1'b0;
    else if (!run)   ov_latch_q <= 1'b0;
    else if (ov_s)   ov_latch_q <= 1'b1;
  end

endmodule

// File: rtl/fg_rv_guard.sv
module fg_rv_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic in_crowbar,
  input  logic rv_low_s,
  input  logic rv_rel_s,
  input  logic rv_rec_s,
  output logic rv_hold_q
);

  logic release_lvl;

  // Inside the crowbar the guard waits for a positive output before letting go.
  assign release_lvl = in_crowbar ? rv_rec_s : rv_rel_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    rv_hold_q <= 1'b0;
    else if (!run)                 rv_hold_q <= 1'b0;
    else if (rv_low_s)             rv_hold_q <= 1'b1;
    else if (release_lvl)          rv_hold_q <= 1'b0;
  end

endmodule

// File: rtl/buck_fault_guard.sv
module buck_fault_guard #(
  parameter int unsigned LATCH_DELAY = 875000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic vcc_ok_i,
  input  logic vcc_uvlo_i,
  input  logic oc_i,
  input  logic pg_fail_i,
  input  logic ov_i,
  input  logic rv_low_i,
  input  logic rv_rel_i,
  input  logic rv_rec_i,
  input  logic hs_req_i,
  input  logic ls_req_i,
  output logic drvh_o,
  output logic drvl_o,
  output logic latched_o,
  output logic run_o,
  output logic pg_force_low_o
);

  import fg_pkg::*;

  fg_flags_t  raw_flags, s_flags;
  logic       run_q, oc_latch_q, ov_latch_q, rv_hold_q;
  drive_sel_e sel;

  assign raw_flags = '{en: en_i, vcc_ok: vcc_ok_i, uvlo: vcc_uvlo_i, oc: oc_i,
                       pg_fail: pg_fail_i, ov: ov_i, rv_low: rv_low_i,
                       rv_rel: rv_rel_i, rv_rec: rv_rec_i};

  fg_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_flags),
    .sync_o  (s_flags)
  );

  fg_supervisor u_sup (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_s     (s_flags.en),
    .vcc_ok_s (s_flags.vcc_ok),
    .uvlo_s   (s_flags.uvlo),
    .run_q    (run_q)
  );

  fg_fault_latch #(.LATCH_DELAY(LATCH_DELAY)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run_q),
    .oc_s       (s_flags.oc),
    .pg_fail_s  (s_flags.pg_fail),
    .ov_s       (s_flags.ov),
    .oc_latch_q (oc_latch_q),
    .ov_latch_q (ov_latch_q)
  );

  fg_rv_guard u_rv (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run_q),
    .in_crowbar (ov_latch_q),
    .rv_low_s   (s_flags.rv_low),
    .rv_rel_s   (s_flags.rv_rel),
    .rv_rec_s   (s_flags.rv_rec),
    .rv_hold_q  (rv_hold_q)
  );

  always_comb begin
    if (!run_q)          sel = SEL_OFF;
    else if (rv_hold_q)  sel = SEL_REVERSE;
    else if (ov_latch_q) sel = SEL_CROWBAR;
    else if (oc_latch_q) sel = SEL_OCLATCH;
    else                 sel = SEL_PASS;
  end

  always_comb begin
    drvh_o = 1'b0;
    drvl_o = 1'b0;
    unique case (sel)
      SEL_CROWBAR: drvl_o = 1'b1;
      SEL_PASS: begin
        drvh_o = hs_req_i;
        drvl_o = ls_req_i && !hs_req_i;
      end
      default: ;
    endcase
  end

  assign latched_o      = oc_latch_q || ov_latch_q;
  assign run_o          = run_q;
  assign pg_force_low_o = !run_q;

endmodule

// File: rtl/buck_fault_guard_chk.sv
module buck_fault_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic hs_req_i,
  input logic ls_req_i,
  input logic drvh_o,
  input logic drvl_o,
  input logic latched_o,
  input logic run_o,
  input logic pg_force_low_o
);

  assert_off_when_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_o |-> (!drvh_o && !drvl_o && pg_force_low_o));

  assert_no_shoot_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(drvh_o && drvl_o));

  assert_hs_needs_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
    drvh_o |-> (hs_req_i && !latched_o));

  assert_ls_unlatched_needs_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (drvl_o && !latched_o) |-> (ls_req_i && !hs_req_i));

  assert_latch_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_o && run_o) |=> (latched_o || !run_o));

  assert_restart_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_o) |-> !latched_o);

endmodule

bind buck_fault_guard buck_fault_guard_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .hs_req_i       (hs_req_i),
  .ls_req_i       (ls_req_i),
  .drvh_o         (drvh_o),
  .drvl_o         (drvl_o),
  .latched_o      (latched_o),
  .run_o          (run_o),
  .pg_force_low_o (pg_force_low_o)
);

// File: tb/buck_fault_guard_tb.sv
`timescale 1ns/1ps
module buck_fault_guard_tb;

  localparam int unsigned DLY = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_i = 0, vcc_ok_i = 0, vcc_uvlo_i = 0, oc_i = 0, pg_fail_i = 0, ov_i = 0;
  logic rv_low_i = 0, rv_rel_i = 1, rv_rec_i = 1, hs_req_i = 0, ls_req_i = 0;
  logic drvh_o, drvl_o, latched_o, run_o, pg_force_low_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  buck_fault_guard #(.LATCH_DELAY(DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .vcc_ok_i(vcc_ok_i), .vcc_uvlo_i(vcc_uvlo_i),
    .oc_i(oc_i), .pg_fail_i(pg_fail_i), .ov_i(ov_i), .rv_low_i(rv_low_i),
    .rv_rel_i(rv_rel_i), .rv_rec_i(rv_rec_i), .hs_req_i(hs_req_i), .ls_req_i(ls_req_i),
    .drvh_o(drvh_o), .drvl_o(drvl_o), .latched_o(latched_o), .run_o(run_o),
    .pg_force_low_o(pg_force_low_o)
  );

  task automatic chk(input string req, input string what, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {drvh_o, drvl_o, latched_o, run_o, pg_force_low_o};
  endfunction

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drive_at_neg();
    @(negedge clk);
  endtask

  // output level: 0 = below -190, 1 = between -190/-150, 2 = between -150/+50, 3 = above +50
  task automatic set_level(input int lvl);
    drive_at_neg();
    rv_low_i = (lvl == 0);
    rv_rel_i = (lvl >= 2);
    rv_rec_i = (lvl == 3);
  endtask

  task automatic restart();
    drive_at_neg(); en_i = 0; edges(4);
    drive_at_neg(); en_i = 1; vcc_ok_i = 1; edges(4);
  endtask

  task automatic t_reset();
    edges(1);
    chk("R3", "reset state", outs(), 5'b00001);
    rst_n = 1'b1;
  endtask

  task automatic t_startup_latency();
    drive_at_neg(); vcc_ok_i = 0; en_i = 1;
    edges(5);
    chk("R2", "no start without supply-good", outs(), 5'b00001);
    drive_at_neg(); vcc_ok_i = 1;
    edges(2);
    chk("R1", "run not before third edge", {4'b0, run_o}, 5'd0);
    edges(1);
    chk("R1", "run at third edge", {4'b0, run_o}, 5'd1);
  endtask

  task automatic t_pass_through();
    drive_at_neg(); hs_req_i = 1; ls_req_i = 0; #1;
    chk("R4", "hs only", outs(), 5'b10010);
    drive_at_neg(); hs_req_i = 0; ls_req_i = 1; #1;
    chk("R4", "ls only", outs(), 5'b01010);
    drive_at_neg(); hs_req_i = 1; ls_req_i = 1; #1;
    chk("R4", "both requests, hs wins", outs(), 5'b10010);
  endtask

  task automatic t_hysteresis_and_uvlo();
    drive_at_neg(); vcc_ok_i = 0; edges(5);
    chk("R2", "keep running between thresholds", outs(), 5'b10010);
    drive_at_neg(); vcc_uvlo_i = 1; edges(5);
    chk("R3", "lockout shuts down", outs(), 5'b00001);
    drive_at_neg(); vcc_uvlo_i = 0; vcc_ok_i = 1; edges(5);
    chk("R2", "restart after supply good", outs(), 5'b10010);
    drive_at_neg(); en_i = 0; edges(5);
    chk("R3", "enable low shuts down", outs(), 5'b00001);
    drive_at_neg(); en_i = 1; edges(5);
  endtask

  task automatic t_overcurrent();
    drive_at_neg(); oc_i = 1; pg_fail_i = 0; edges(DLY + 10);
    chk("R5", "overcurrent alone no latch", outs(), 5'b10010);
    drive_at_neg(); pg_fail_i = 1; edges(DLY / 2);
    drive_at_neg(); pg_fail_i = 0; edges(4);
    drive_at_neg(); pg_fail_i = 1; edges(DLY / 2);
    chk("R5", "interrupted count no latch", outs(), 5'b10010);
    drive_at_neg(); pg_fail_i = 0; edges(4);
    drive_at_neg(); pg_fail_i = 1;
    edges(DLY + 1);
    chk("R5", "one edge before delay", {4'b0, latched_o}, 5'd0);
    edges(1);
    chk("R5", "latched at delay", outs(), 5'b00110);
    drive_at_neg(); oc_i = 0; pg_fail_i = 0; edges(6);
    chk("R7", "overcurrent latch sticks", outs(), 5'b00110);
    restart();
    chk("R7", "enable pulse clears latch", outs(), 5'b10010);
  endtask

  task automatic t_crowbar();
    drive_at_neg(); ov_i = 1; edges(4);
    drive_at_neg(); ov_i = 0; edges(4);
    chk("R6", "crowbar latched", outs(), 5'b01110);
    drive_at_neg(); hs_req_i = 0; ls_req_i = 0; #1;
    chk("R6", "requests ignored in crowbar", outs(), 5'b01110);
    set_level(0); edges(4);
    chk("R9", "reverse in crowbar cuts ls", outs(), 5'b00110);
    set_level(2); edges(6);
    chk("R9", "-150 mV not enough", outs(), 5'b00110);
    set_level(3); edges(4);
    chk("R9", "+50 mV restores ls", outs(), 5'b01110);
    drive_at_neg(); vcc_uvlo_i = 1; vcc_ok_i = 0; edges(4);
    chk("R10", "shutdown beats crowbar", outs(), 5'b00001);
    drive_at_neg(); vcc_uvlo_i = 0; vcc_ok_i = 1; hs_req_i = 1; edges(5);
    chk("R7", "lockout cycle clears crowbar", outs(), 5'b10010);
  endtask

  task automatic t_reverse_normal();
    drive_at_neg(); hs_req_i = 1; ls_req_i = 0;
    set_level(0); edges(4);
    chk("R8", "reverse forces both low", outs(), 5'b00010);
    set_level(1); edges(6);
    chk("R8", "still held inside hysteresis", outs(), 5'b00010);
    set_level(2); edges(4);
    chk("R8", "released above -150 mV", outs(), 5'b10010);
    set_level(3);
    drive_at_neg(); ov_i = 1; set_level(0); edges(5);
    chk("R10", "reverse beats crowbar", outs(), 5'b00110);
    drive_at_neg(); ov_i = 0; set_level(3); edges(5);
    chk("R10", "crowbar after reverse clears", outs(), 5'b01110);
    restart();
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_startup_latency();
    t_pass_through();
    t_hysteresis_and_uvlo();
    t_overcurrent();
    t_crowbar();
    t_reverse_normal();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule